// File: doc/BRIEF.md
# Self-Training Read Resynchronization Buffer

This block carries read data from the memory's capture clock into the system clock. The two clocks run at the same frequency, but their phase relation is not known. Data passes through a small dual-port ring. The capture side writes one entry on every capture-clock edge, and the system side reads one entry on every system-clock edge. There is no handshake. The distance between the two pointers sets how long data waits in the ring.

After reset the block holds the controller paused. It waits for the delay-locked loop to report lock, then parks the read pointer and afterwards lets the write pointer run. It then takes over the memory command, address and write-data lines. On every cycle it writes one word of a non-repeating tagged sequence to a single training address and reads that address back in the same cycle. A fixed number of cycles after start are ignored. After that, the returned word is checked against the word the block expects in the target cycle at regular intervals. An early word makes the read pointer pause for one cycle, and a late word makes it skip one entry. Two on-time checks in a row finish training and hand the lines back to the controller. If too many checks miss, training stops and a failure flag is raised.

Once trained, every read the controller issues returns on `rd_data` exactly `TARGET_LAT` system cycles later. This holds for any memory round trip that the ring depth can absorb.

Top module: `rd_align_buf`

## Requirements
- R1: While reset is released and `dll_locked` is low, `ctl_stall`=1, `trained`=0, `failed`=0, `mem_rd`=0 and `mem_wr`=0.
- R2: While training traffic runs, every cycle has `mem_rd`=1, `mem_wr`=1 and `mem_addr`=`TRAIN_ADDR`. `mem_wdata` carries a tag T in the upper half and ~T in the lower half. T is 0 on the first cycle and increases by one (modulo 2^(DW/2)) each cycle.
- R3: `ctl_stall` is 1 from reset until `trained` or `failed` rises, and 0 from then on. While it is 0, the four memory outputs equal the four controller inputs in the same cycle.
- R4: No check takes place, and the read pointer advances by exactly one per cycle, during the first `IGNORE_CYC` cycles of training traffic. The first check falls on cycle `IGNORE_CYC`+1 of training, and later checks follow every `SETTLE_CYC`+1 cycles.
- R5: At a check, a word is on time when its tag equals the current issue tag minus `TARGET_LAT`. An early word (newer tag) makes the read pointer hold for one cycle. A late word (older tag) makes it advance by two. Otherwise it advances by one.
- R6: `trained` rises after two consecutive on-time checks and then stays high until reset.
- R7: Once trained, a read issued in system cycle c shows its data on `rd_data` during cycle c+`TARGET_LAT`, for any round trip the ring depth can absorb.
- R8: A check that is not on time, including a word whose lower half is not the inverse of its upper half, counts as a miss. The `DEPTH`-th miss raises `failed`, which then stays high while `trained` stays 0.
- R9: The read pointer is parked at 0 before the write pointer is released. The write pointer stays at `DEPTH`/2 while its synchronized hold is active.
- R10: The ring runs freely. Once released, the write pointer advances by one on every capture edge. After training, the read pointer advances by one on every system edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock |
| sys_rst_n | input | 1 | System-domain asynchronous reset, active low |
| cap_clk | input | 1 | Capture clock, same frequency as sys_clk |
| cap_rst_n | input | 1 | Capture-domain asynchronous reset, active low |
| dll_locked | input | 1 | DLL stable indication, system domain |
| ctl_rd | input | 1 | Controller read command |
| ctl_wr | input | 1 | Controller write command |
| ctl_addr | input | MAW | Controller address |
| ctl_wdata | input | DW | Controller write data |
| ctl_stall | output | 1 | Controller pause while training owns the memory lines |
| mem_rd | output | 1 | Read command to memory |
| mem_wr | output | 1 | Write command to memory |
| mem_addr | output | MAW | Address to memory |
| mem_wdata | output | DW | Write data to memory |
| cap_data | input | DW | Read data captured in the capture domain |
| rd_data | output | DW | Read data in the system domain |
| trained | output | 1 | Training finished on time |
| failed | output | 1 | Training gave up |

## Verification
The bench trains the block against a short round trip and against a long one. The short one forces early corrections and the long one forces late corrections, and after each the bench measures the exact read latency. A sign error in the early/late decision would drive the pointer the wrong way, so the block would end in `failed` or would return data at the wrong cycle. A stuck memory that returns zeros has to produce `failed` at one exact cycle count after lock. A block that counted ignored cycles, counted checks twice or waited the wrong settle time would fail there too soon or too late. Every cycle the bench also compares the training traffic's tag sequence and the pass-through of controller commands against its own model.

// File: rtl/rab_pkg.sv
package rab_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_DLL = 3'd0,
    ST_PTR_RST  = 3'd1,
    ST_TRAIN    = 3'd2,
    ST_DONE     = 3'd3,
    ST_FAIL     = 3'd4
  } trn_state_e;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_EARLY  = 2'd1,
    CLS_LATE   = 2'd2,
    CLS_ONTIME = 2'd3
  } chk_cls_e;

  // read pointer increment chosen by a check result
  function automatic logic [1:0] step_of(chk_cls_e c);
    case (c)
      CLS_EARLY: return 2'd0;
      CLS_LATE:  return 2'd2;
      default:   return 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/rab_ring.sv
module rab_ring #(
  parameter int DW       = 16,
  parameter int DEPTH    = 8,
  parameter int SYNC_LEN = 2,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic          cap_clk,
  input  logic          cap_rst_n,
  input  logic [DW-1:0] cap_data,
  input  logic          sys_clk,
  input  logic          sys_rst_n,
  input  logic          wp_hold,
  input  logic          rptr_load,
  input  logic [1:0]    rptr_step,
  output logic [DW-1:0] rd_data,
  output logic [AW-1:0] wptr_o,
  output logic [AW-1:0] rptr_o,
  output logic          wp_run
);

  localparam logic [AW-1:0] WPTR_INIT = AW'(DEPTH / 2);

  logic [DW-1:0]       store [DEPTH];
  logic [SYNC_LEN-1:0] hold_sh;
  logic [AW-1:0]       wptr;
  logic [AW-1:0]       rptr;

  // hold request crosses into the capture domain
  always_ff @(posedge cap_clk or negedge cap_rst_n) begin
    if (!cap_rst_n) hold_sh <= '1;
    else            hold_sh <= {hold_sh[SYNC_LEN-2:0], wp_hold};
  end

  assign wp_run = !hold_sh[SYNC_LEN-1];

  always_ff @(posedge cap_clk or negedge cap_rst_n) begin
    if (!cap_rst_n)   wptr <= WPTR_INIT;
    else if (!wp_run) wptr <= WPTR_INIT;
    else              wptr <= wptr + AW'(1);
  end

  always_ff @(posedge cap_clk) begin
    store[wptr] <= cap_data;
  end

  always_ff @(posedge sys_clk or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      rptr    <= '0;
      rd_data <= '0;
    end else begin
      rd_data <= store[rptr];
      if (rptr_load) rptr <= '0;
      else           rptr <= rptr + AW'(rptr_step);
    end
  end

  assign wptr_o = wptr;
  assign rptr_o = rptr;

endmodule

// File: rtl/rab_trainer.sv
module rab_trainer
  import rab_pkg::*;
#(
  parameter int DW         = 16,
  parameter int DEPTH      = 8,
  parameter int TARGET_LAT = 10,
  parameter int IGNORE_CYC = 16,
  parameter int SETTLE_CYC = 3,
  parameter int RST_CYC    = 4,
  localparam int TW        = DW / 2,
  localparam int IW        = $clog2(IGNORE_CYC + 1),
  localparam int GW        = $clog2(SETTLE_CYC + 1),
  localparam int MW        = $clog2(DEPTH + 1),
  localparam int RW        = $clog2(RST_CYC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dll_locked,
  input  logic [DW-1:0] rd_data,
  output logic          stall,
  output logic          gen_active,
  output logic [DW-1:0] gen_word,
  output logic          rptr_load,
  output logic          wp_hold,
  output logic [1:0]    rptr_step,
  output logic          ign_open,
  output logic          chk_fire,
  output chk_cls_e      chk_cls,
  output logic          trained,
  output logic          failed
);

  function automatic logic [DW-1:0] mk_word(logic [TW-1:0] t);
    return {t, ~t};
  endfunction

  function automatic logic word_ok(logic [DW-1:0] w);
    return w[TW-1:0] == ~w[DW-1:TW];
  endfunction

  // compare the tag that arrived against the tag due in this cycle
  function automatic chk_cls_e classify(logic [TW-1:0] due, logic [DW-1:0] w);
    logic [TW-1:0] d;
    d = due - w[DW-1:TW];
    if (!word_ok(w))  return CLS_NONE;
    else if (d == '0) return CLS_ONTIME;
    else if (d[TW-1]) return CLS_EARLY;
    else              return CLS_LATE;
  endfunction

  trn_state_e    st;
  logic [RW-1:0] rcnt;
  logic [IW-1:0] ign;
  logic [GW-1:0] gap;
  logic [MW-1:0] miss;
  logic          streak;
  logic [TW-1:0] gen_tag;
  logic [TW-1:0] due_tag;

  assign due_tag    = gen_tag - TW'(TARGET_LAT);
  assign gen_active = (st == ST_TRAIN);
  assign gen_word   = mk_word(gen_tag);
  assign stall      = (st != ST_DONE) && (st != ST_FAIL);
  assign rptr_load  = (st == ST_WAIT_DLL) || (st == ST_PTR_RST);
  assign wp_hold    = rptr_load;
  assign ign_open   = (ign == IW'(IGNORE_CYC));
  assign chk_fire   = gen_active && ign_open && (gap == '0);
  assign chk_cls    = classify(due_tag, rd_data);
  assign rptr_step  = chk_fire ? step_of(chk_cls) : 2'd1;
  assign trained    = (st == ST_DONE);
  assign failed     = (st == ST_FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_WAIT_DLL;
      rcnt    <= '0;
      ign     <= '0;
      gap     <= '0;
      miss    <= '0;
      streak  <= 1'b0;
      gen_tag <= '0;
    end else begin
      case (st)
        ST_WAIT_DLL: begin
          rcnt <= '0;
          if (dll_locked) st <= ST_PTR_RST;
        end
        ST_PTR_RST: begin
          if (rcnt == RW'(RST_CYC - 1)) begin
            st      <= ST_TRAIN;
            ign     <= '0;
            gap     <= '0;
            miss    <= '0;
            streak  <= 1'b0;
            gen_tag <= '0;
          end else begin
            rcnt <= rcnt + RW'(1);
          end
        end
        ST_TRAIN: begin
          gen_tag <= gen_tag + TW'(1);
          if (!ign_open) ign <= ign + IW'(1);
          if (chk_fire) begin
            gap <= GW'(SETTLE_CYC);
            if (chk_cls == CLS_ONTIME) begin
              streak <= 1'b1;
              if (streak) st <= ST_DONE;
            end else begin
              streak <= 1'b0;
              miss   <= miss + MW'(1);
              if (miss == MW'(DEPTH - 1)) st <= ST_FAIL;
            end
          end else if (ign_open) begin
            gap <= gap - GW'(1);
          end
        end
        default: st <= st;
      endcase
    end
  end

endmodule

// File: rtl/rd_align_buf.sv
module rd_align_buf
  import rab_pkg::*;
#(
  parameter int             DW         = 16,
  parameter int             MAW        = 10,
  parameter logic [MAW-1:0] TRAIN_ADDR = '1,
  parameter int             DEPTH      = 8,
  parameter int             TARGET_LAT = 10,
  parameter int             IGNORE_CYC = 16,
  parameter int             SETTLE_CYC = 3,
  parameter int             RST_CYC    = 4,
  localparam int            AW         = $clog2(DEPTH)
) (
  input  logic           sys_clk,
  input  logic           sys_rst_n,
  input  logic           cap_clk,
  input  logic           cap_rst_n,
  input  logic           dll_locked,
  input  logic           ctl_rd,
  input  logic           ctl_wr,
  input  logic [MAW-1:0] ctl_addr,
  input  logic [DW-1:0]  ctl_wdata,
  output logic           ctl_stall,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic [MAW-1:0] mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic [DW-1:0]  cap_data,
  output logic [DW-1:0]  rd_data,
  output logic           trained,
  output logic           failed
);

  // named internal events, also watched by the checker
  logic          gen_active;
  logic [DW-1:0] gen_word;
  logic          rptr_load;
  logic          wp_hold;
  logic [1:0]    rptr_step;
  logic          ign_open;
  logic          chk_fire;
  chk_cls_e      chk_cls;
  logic [AW-1:0] wptr_q;
  logic [AW-1:0] rptr_q;
  logic          wp_run;

  rab_trainer #(
    .DW(DW), .DEPTH(DEPTH), .TARGET_LAT(TARGET_LAT),
    .IGNORE_CYC(IGNORE_CYC), .SETTLE_CYC(SETTLE_CYC), .RST_CYC(RST_CYC)
  ) u_trn (
    .clk(sys_clk), .rst_n(sys_rst_n), .dll_locked(dll_locked),
    .rd_data(rd_data), .stall(ctl_stall), .gen_active(gen_active),
    .gen_word(gen_word), .rptr_load(rptr_load), .wp_hold(wp_hold),
    .rptr_step(rptr_step), .ign_open(ign_open), .chk_fire(chk_fire),
    .chk_cls(chk_cls), .trained(trained), .failed(failed)
  );

  rab_ring #(.DW(DW), .DEPTH(DEPTH), .SYNC_LEN(2)) u_ring (
    .cap_clk(cap_clk), .cap_rst_n(cap_rst_n), .cap_data(cap_data),
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .wp_hold(wp_hold),
    .rptr_load(rptr_load), .rptr_step(rptr_step), .rd_data(rd_data),
    .wptr_o(wptr_q), .rptr_o(rptr_q), .wp_run(wp_run)
  );

  // trainer owns the memory lines while the controller is paused
  assign mem_rd    = ctl_stall ? gen_active : ctl_rd;
  assign mem_wr    = ctl_stall ? gen_active : ctl_wr;
  assign mem_addr  = ctl_stall ? TRAIN_ADDR : ctl_addr;
  assign mem_wdata = ctl_stall ? gen_word   : ctl_wdata;

endmodule

// File: rtl/rab_chk.sv
module rab_chk #(
  parameter int             MAW        = 10,
  parameter logic [MAW-1:0] TRAIN_ADDR = '1,
  parameter int             DEPTH      = 8,
  localparam int            AW         = $clog2(DEPTH)
) (
  input logic           sys_clk,
  input logic           sys_rst_n,
  input logic           cap_clk,
  input logic           cap_rst_n,
  input logic           ctl_stall,
  input logic           trained,
  input logic           failed,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic [MAW-1:0] mem_addr,
  input logic           gen_active,
  input logic           ign_open,
  input logic [AW-1:0]  rptr_q,
  input logic [AW-1:0]  wptr_q,
  input logic           wp_run
);

  localparam logic [AW-1:0] WPTR_INIT = AW'(DEPTH / 2);

  p_train_traffic_r2: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (ctl_stall && mem_wr) |-> (mem_rd && mem_addr == TRAIN_ADDR));

  p_ignore_window_r4: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (gen_active && !ign_open) |=> (rptr_q == AW'($past(rptr_q) + AW'(1))));

  p_step_range_r5: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    gen_active |=> (AW'(rptr_q - $past(rptr_q)) <= AW'(2)));

  p_done_sticky_r6: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    trained |=> (trained && !ctl_stall));

  p_fail_sticky_r8: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    failed |=> (failed && !trained && !ctl_stall));

  p_wptr_held_r9: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
    !wp_run |=> (wptr_q == WPTR_INIT));

  p_wptr_runs_r10: assert property (@(posedge cap_clk) disable iff (!cap_rst_n)
    wp_run |=> (wptr_q == AW'($past(wptr_q) + AW'(1))));

  p_rptr_runs_r10: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    trained |=> (rptr_q == AW'($past(rptr_q) + AW'(1))));

endmodule

bind rd_align_buf rab_chk #(.MAW(MAW), .TRAIN_ADDR(TRAIN_ADDR), .DEPTH(DEPTH)) u_chk (
  .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .cap_clk(cap_clk), .cap_rst_n(cap_rst_n),
  .ctl_stall(ctl_stall), .trained(trained), .failed(failed), .mem_rd(mem_rd),
  .mem_wr(mem_wr), .mem_addr(mem_addr), .gen_active(gen_active), .ign_open(ign_open),
  .rptr_q(rptr_q), .wptr_q(wptr_q), .wp_run(wp_run)
);

// File: tb/tb_rd_align_buf.sv
`timescale 1ns/1ps
module tb_rd_align_buf;

  localparam int DW = 16, MAW = 10, DEPTH = 8, TGT = 10, IGN = 16, SETL = 3, RSTC = 4;
  localparam logic [MAW-1:0] TADDR = '1;
  localparam int FAIL_AT = 1 + RSTC + IGN + 1 + (DEPTH - 1) * (SETL + 1);

  logic clk = 0, cap_clk = 0, rst_n = 0, dll = 0;
  logic ctl_rd = 0, ctl_wr = 0;
  logic [MAW-1:0] ctl_addr = '0;
  logic [DW-1:0] ctl_wdata = '0, cap_data = '0;
  logic stall, mem_rd, mem_wr, trained, failed;
  logic [MAW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, rd_data;

  int errors = 0, checks = 0, cyc = 0, rt = 2;
  bit stuck = 0, prev_ok = 0, track = 0;
  logic [7:0] prev_tag;
  logic [DW-1:0] bmem [int];
  logic [DW-1:0] line [0:11];
  int due_q[$];
  logic [DW-1:0] exp_q[$];
  logic [DW-1:0] shadow [int];

  rd_align_buf #(.DW(DW), .MAW(MAW), .TRAIN_ADDR(TADDR), .DEPTH(DEPTH), .TARGET_LAT(TGT),
    .IGNORE_CYC(IGN), .SETTLE_CYC(SETL), .RST_CYC(RSTC)) dut (
    .sys_clk(clk), .sys_rst_n(rst_n), .cap_clk(cap_clk), .cap_rst_n(rst_n),
    .dll_locked(dll), .ctl_rd(ctl_rd), .ctl_wr(ctl_wr), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .ctl_stall(stall), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cap_data(cap_data),
    .rd_data(rd_data), .trained(trained), .failed(failed));

  always #4 clk = ~clk;  // 125 MHz
  initial begin
    #3;
    forever begin cap_clk = 1; #4; cap_clk = 0; #4; end
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // memory model: write applied first, response delayed by rt cycles
  always @(negedge clk) begin
    logic [DW-1:0] resp;
    resp = '0;
    if (mem_wr) bmem[int'(mem_addr)] = mem_wdata;
    if (mem_rd) resp = bmem.exists(int'(mem_addr)) ? bmem[int'(mem_addr)] : '0;
    for (int j = 11; j > 0; j--) line[j] = line[j-1];
    line[0] = resp;
  end
  always @(negedge cap_clk) cap_data <= stuck ? '0 : line[rt];

  // cycle-by-cycle reference checks
  always @(negedge clk) begin
    if (!rst_n) prev_ok = 0;
    else begin
      if (!stall) begin
        chk(mem_rd == ctl_rd && mem_wr == ctl_wr, "R3 cmd pass", {mem_rd, mem_wr}, {ctl_rd, ctl_wr});
        chk(mem_addr == ctl_addr && mem_wdata == ctl_wdata, "R3 addr/data pass", mem_wdata, ctl_wdata);
      end else if (mem_wr) begin
        chk(mem_rd && mem_addr == TADDR, "R2 train addr", mem_addr, TADDR);
        chk(mem_wdata[7:0] == ~mem_wdata[15:8], "R2 word form", mem_wdata, {mem_wdata[15:8], ~mem_wdata[15:8]});
        if (prev_ok) chk(mem_wdata[15:8] == prev_tag + 8'd1, "R2 tag step", mem_wdata[15:8], prev_tag + 8'd1);
        else         chk(mem_wdata[15:8] == 8'd0, "R2 first tag", mem_wdata[15:8], 0);
        prev_tag = mem_wdata[15:8];
        prev_ok  = 1;
      end else begin
        chk(!mem_rd, "R2 idle rd", mem_rd, 0);
      end
      chk(!(trained && failed), "R8 exclusive", {trained, failed}, 0);
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        chk(rd_data == exp_q[0], "R7 latency data", rd_data, exp_q[0]);
        void'(due_q.pop_front());
        void'(exp_q.pop_front());
      end
    end
  end

  task automatic op(input bit r, input bit w, input int a, input logic [DW-1:0] d);
    @(posedge clk); #1;
    ctl_rd = r; ctl_wr = w; ctl_addr = MAW'(a); ctl_wdata = d;
    if (w) shadow[a] = d;
    if (r && track) begin
      due_q.push_back(cyc + TGT);
      exp_q.push_back(shadow.exists(a) ? shadow[a] : '0);
    end
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 0; dll = 0; ctl_rd = 0; ctl_wr = 0; track = 0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(stall && !trained && !failed, "R1 reset flags", {stall, trained, failed}, 3'b100);
      chk(!mem_rd && !mem_wr, "R1 reset idle", {mem_rd, mem_wr}, 0);
    end
  endtask

  task automatic run_train(output int n);
    @(posedge clk); #1 dll = 1;
    n = 0;
    for (int k = 0; k < 1000; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (trained || failed) break;
    end
  endtask

  task automatic traffic();
    track = 1;
    for (int i = 0; i < 8; i++) op(0, 1, i * 3, DW'(16'hA500 ^ (i * 37)));
    for (int i = 0; i < 8; i++) op(1, 0, i * 3, '0);
    for (int i = 0; i < 6; i++) op(1, 1, 100 + (i % 2), DW'(16'h3C00 + i));
    op(1, 0, 101, '0);
    op(0, 0, 0, '0);
    repeat (TGT + 3) @(posedge clk);
    @(negedge clk);
    chk(due_q.size() == 0, "R7 all reads returned", due_q.size(), 0);
    chk(trained && !stall, "R6 trained stays", {trained, stall}, 2'b10);
    track = 0;
  endtask

  initial begin
    int n;
    for (int j = 0; j < 12; j++) line[j] = '0;
    // stuck memory: every check misses, fail at an exact cycle
    stuck = 1;
    do_reset();
    run_train(n);
    chk(failed && n == FAIL_AT, "R8/R4 fail timing", n, FAIL_AT);
    chk(!trained && !stall, "R8 control released", {trained, stall}, 0);
    op(1, 1, 5, 16'h1234);
    op(0, 0, 0, '0);
    @(negedge clk);
    chk(failed, "R8 fail sticky", failed, 1);
    // short round trip: early words, pointer must hold
    stuck = 0; rt = 2;
    do_reset();
    run_train(n);
    chk(trained && !failed, "R5/R6/R9 converge short trip", {trained, failed}, 2'b10);
    traffic();
    // long round trip: late words, pointer must skip
    rt = 8;
    do_reset();
    run_train(n);
    chk(trained && !failed, "R5/R6/R9 converge long trip", {trained, failed}, 2'b10);
    traffic();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule